// File: doc/BRIEF.md
# Gated Edge-Counting Logic Probe

This block looks at one asynchronous digital input and decides whether it is toggling, sitting high, or sitting low. A one-cycle start request clears an internal falling-edge counter and opens a measurement gate. The gate stays open for one tenth of a second of system clock. While it is open, falling edges on a synchronized copy of the input are counted.

When the gate closes, the block subtracts one from the count. If anything is left, the input is classified as pulsing. Otherwise the classification is the synchronized level at the closing cycle. A single stray edge is therefore tolerated. The verdict is presented on a 2-bit result together with a one-cycle done strobe.

The edge counter saturates instead of wrapping, so a fast input is never misread as static. Start requests made while a measurement is running are ignored.

Top module: `probe_classifier`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `result` is 2'b00.
- R2: A start request accepted while idle raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` is asserted, and it is low in that cycle.
- R3: `done` is high for exactly one cycle. It is registered GATE_CYCLES = CLK_HZ/10 clock edges after the edge that samples the accepted start.
- R4: Result encoding is 2'b00 static low, 2'b01 static high and 2'b10 pulsing. The value 2'b11 never appears with `done`.
- R5: Two or more falling edges of the input inside the gate give 2'b10.
- R6: With no falling edge inside the gate, the result is the synchronized input level at gate close.
- R7: Exactly one falling edge inside the gate is tolerated, and the result is the level at gate close.
- R8: Each start clears the edge count, so edges counted in an earlier gate do not add to a later one.
- R9: Input edges while the gate is closed are not counted.
- R10: A start request while `busy` is high is ignored. It neither restarts nor extends the gate and produces no extra `done`.
- R11: The edge counter saturates at its maximum. A number of edges beyond the counter range still reports 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_in | input | 1 | Asynchronous signal under test |
| start | input | 1 | One-cycle request to begin a measurement |
| busy | output | 1 | High while the gate is open |
| result | output | 2 | Classification, held until the next done |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that `start` is a synchronous single-cycle request. They also assume that the probe's classification depends only on edges that have passed the synchronizer inside the gate. The stimulus therefore changes the probe only at falling clock edges, a few cycles apart. It sets the pre-gate level and lets it settle before each start, and it keeps every edge well inside the window. This means the two-to-three-cycle synchronizer latency never moves an edge across a gate boundary. Extra start pulses are issued only mid-window, to exercise the ignore rule.

// File: rtl/probe_pkg.sv
// Package: shared result codes for the logic probe.
// Assumes: a 2-bit code is carried on the top-level result port.
package probe_pkg;
    typedef enum logic [1:0] {
        RES_LOW   = 2'b00,
        RES_HIGH  = 2'b01,
        RES_PULSE = 2'b10
    } probe_res_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_GATE = 1'b1
    } probe_state_e;
endpackage

// File: rtl/probe_sync.sv
// Module: probe_sync
// Brings the asynchronous probe into the clock domain through SYNC_STAGES
// flops, and flags a falling edge by comparing the last stage with one
// extra history flop.
// Assumes: SYNC_STAGES >= 2.
module probe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic fall
);
    logic [SYNC_STAGES-1:0] stages;
    logic                   prev;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '0;
        end else begin
            stages <= {stages[SYNC_STAGES-2:0], async_in};
        end
    end

    // Keep the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= stages[SYNC_STAGES-1];
        end
    end

    assign level = stages[SYNC_STAGES-1];
    assign fall  = prev & ~stages[SYNC_STAGES-1];
endmodule

// File: rtl/gate_timer.sv
// Module: gate_timer
// Counts the cycles of an open gate and flags the cycle in which it closes.
// Assumes: GATE_CYCLES >= 2; clr and run are never high together with run
// expected to continue from a cleared count.
module gate_timer #(
    parameter int GATE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic last
);
    localparam int TW = $clog2(GATE_CYCLES);
    localparam logic [TW-1:0] TLAST = TW'(GATE_CYCLES - 1);

    logic [TW-1:0] cnt;

    // Advance the window counter while the gate is open.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == TLAST) ? '0 : cnt + 1'b1;
        end
    end

    assign last = run && (cnt == TLAST);
endmodule

// File: rtl/edge_counter.sv
// Module: edge_counter
// Saturating counter of detected edges; clr wins over inc.
// Assumes: EDGE_W >= 2. cnt_next shows the value including this cycle's edge.
module edge_counter #(
    parameter int EDGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [EDGE_W-1:0] cnt,
    output logic [EDGE_W-1:0] cnt_next
);
    localparam logic [EDGE_W-1:0] CMAX = '1;

    // Next value: clear, saturating increment, or hold.
    always_comb begin
        if (clr) begin
            cnt_next = '0;
        end else if (inc && cnt != CMAX) begin
            cnt_next = cnt + 1'b1;
        end else begin
            cnt_next = cnt;
        end
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_next;
        end
    end
endmodule

// File: rtl/probe_classifier.sv
// Module: probe_classifier (top)
// Opens a gate of CLK_HZ/10 cycles on an idle start, counts falling edges of
// the synchronized probe, then reports pulse / high / low with a done strobe.
// Assumes: start is synchronous to clk; CLK_HZ/10 >= 2.
module probe_classifier #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int EDGE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       probe_in,
    input  logic       start,
    output logic       busy,
    output logic [1:0] result,
    output logic       done
);
    import probe_pkg::*;

    localparam int GATE_CYCLES = CLK_HZ / 10;

    probe_state_e      state;
    logic              start_ok;
    logic              gate_last;
    logic              lvl;
    logic              fall;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edge_cnt_next;
    probe_res_e        verdict;

    assign start_ok = start && (state == ST_IDLE);
    assign busy     = (state == ST_GATE);

    probe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (probe_in),
        .level    (lvl),
        .fall     (fall)
    );

    gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ok),
        .run   (busy),
        .last  (gate_last)
    );

    edge_counter #(.EDGE_W(EDGE_W)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_ok),
        .inc      (busy && fall),
        .cnt      (edge_cnt),
        .cnt_next (edge_cnt_next)
    );

    // Classify at gate close: count minus one above zero means pulsing.
    always_comb begin
        if (edge_cnt_next > EDGE_W'(1)) begin
            verdict = RES_PULSE;
        end else if (lvl) begin
            verdict = RES_HIGH;
        end else begin
            verdict = RES_LOW;
        end
    end

    // Gate state machine with registered result and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            result <= RES_LOW;
        end else begin
            done <= 1'b0;
            if (start_ok) begin
                state <= ST_GATE;
            end else if (busy && gate_last) begin
                state  <= ST_IDLE;
                done   <= 1'b1;
                result <= verdict;
            end
        end
    end
endmodule

// File: rtl/probe_classifier_chk.sv
// Module: probe_classifier_chk
// Assertion checker bound to probe_classifier.
// Assumes: it is attached through the bind below and sees the internal edge count.
module probe_classifier_chk #(
    parameter int EDGE_W      = 8,
    parameter int GATE_CYCLES = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [1:0]        result,
    input logic [EDGE_W-1:0] edge_cnt
);
    int busy_run;

    // Count consecutive busy cycles to check the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (busy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && result == 2'b00));

    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r2_busy_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_run == GATE_CYCLES));

    a_r4_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'b11));

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> (edge_cnt >= $past(edge_cnt)));
endmodule

bind probe_classifier probe_classifier_chk #(
    .EDGE_W      (EDGE_W),
    .GATE_CYCLES (GATE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .edge_cnt (edge_cnt)
);

// File: tb/tb_probe_classifier.sv
module tb_probe_classifier;
    localparam int CLK_HZ = 1000;
    localparam int N      = CLK_HZ / 10;

    typedef struct {
        logic [1:0] res;
        string      tag;
        int         cyc;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       probe_in = 1'b0;
    logic       start = 1'b0;
    logic       busy;
    logic [1:0] result;
    logic       done;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   prev_done = 1'b0;
    exp_t sb[$];

    probe_classifier #(.CLK_HZ(CLK_HZ), .EDGE_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .probe_in(probe_in), .start(start),
        .busy(busy), .result(result), .done(done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pop the expected item on each done and compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                check(!prev_done, "R3 done longer than one cycle", 1, 0);
                check(!busy, "R2 busy during done", busy, 0);
                if (!prev_done) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R10 unexpected done", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(result == e.res, e.tag, result, e.res);
                        check(cyc == e.cyc, "R3 done timing", cyc, e.cyc);
                    end
                end
            end
            prev_done = done;
        end
    end

    // Driver: settle the level, start, push the expectation, make the edges.
    task automatic do_sample(input logic [1:0] exp, input string tag,
                             input int nfalls, input logic endlvl, input bit restart);
        exp_t e;
        probe_in = (nfalls > 0) ? 1'b1 : endlvl;
        cycles(6);
        start = 1'b1;
        e.res = exp; e.tag = tag; e.cyc = cyc + 1 + N;
        sb.push_back(e);
        cycles(1);
        start = 1'b0;
        cycles(4);
        check(busy == 1'b1, "R2 busy in window", busy, 1);
        if (restart) begin
            start = 1'b1;
            cycles(1);
            start = 1'b0;
        end
        cycles(5);
        for (int i = 0; i < nfalls; i++) begin
            probe_in = 1'b0;
            cycles(3);
            if (!(i == nfalls - 1 && endlvl == 1'b0)) probe_in = 1'b1;
            cycles(3);
        end
        wait (sb.size() == 0);
        cycles(3);
    endtask

    initial begin
        cycles(3);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(result == 2'b00, "R1 result after reset", result, 0);
        rst_n = 1'b1;
        cycles(2);

        do_sample(2'b00, "R6 static low", 0, 1'b0, 1'b0);
        do_sample(2'b01, "R6 static high", 0, 1'b1, 1'b0);
        do_sample(2'b00, "R7 one fall ending low", 1, 1'b0, 1'b0);
        do_sample(2'b01, "R7 one fall ending high", 1, 1'b1, 1'b0);
        do_sample(2'b10, "R5 two falls", 2, 1'b1, 1'b0);
        do_sample(2'b10, "R5 three falls ending low", 3, 1'b0, 1'b0);
        do_sample(2'b00, "R8 first single edge", 1, 1'b0, 1'b0);
        do_sample(2'b00, "R8 count cleared", 1, 1'b0, 1'b0);

        // R9: toggle while idle, then a static-high window.
        for (int i = 0; i < 10; i++) begin
            probe_in = ~probe_in;
            cycles(3);
        end
        check(done == 1'b0 && busy == 1'b0, "R9 idle edges no activity", done, 0);
        do_sample(2'b01, "R9 idle edges ignored", 0, 1'b1, 1'b0);

        do_sample(2'b01, "R10 restart ignored", 1, 1'b1, 1'b1);
        do_sample(2'b10, "R11 eight falls saturate", 8, 1'b1, 1'b0);
        do_sample(2'b10, "R11 nine falls saturate", 9, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule